// File: doc/BRIEF.md
# ADC Offset Compensation Calibrator

This block measures the offset of a 10-bit converter without software involvement. When `start` is pulsed while the block is idle, it raises `cal_mode`. Outside logic uses `cal_mode` to force the converter input to half of the reference on the first channel. The block then waits a settling interval. After that it collects a fixed number of samples over a valid/ready stream. It waits one full conversion period before each capture, so that every sample it takes is a new conversion.

When the last sample is in, the block drops `cal_mode`, which lets the surrounding control fall back to its earlier settings. It then publishes a signed correction equal to mid-scale minus the truncated mean of the samples. In battery mode the correction is multiplied by the divider gain: ×3 when `div_sel` is 1, ×3/2 when it is 0. The block pulses `done` for one cycle. Converter behaviour and register decoding are handled elsewhere.

The sample stream follows the usual rules. A sample moves only in a cycle where `smp_valid` and `smp_ready` are both high. The block holds `smp_ready` high until the source answers, and it never drops ready on its own while waiting. Data offered while ready is low is not consumed, and the source is free to hold it or change it.

Top module: `adc_offset_cal`

## Requirements
- R1: During and right after reset, `busy`, `done`, `cal_mode` and `smp_ready` are 0 and `comp_val` is 0.
- R2: A `start` seen while idle raises `busy` and `cal_mode` from the next cycle. `batt_en` and `div_sel` are captured in that same cycle, and later changes to them have no effect on the run.
- R3: `smp_ready` first rises exactly SETTLE_CYC + GAP_CYC cycles after the start cycle. With the defaults that is 212 cycles.
- R4: After each accepted sample, `smp_ready` stays low for exactly GAP_CYC cycles (default 12) and then rises again.
- R5: A sample is taken only when `smp_valid` and `smp_ready` are both high. Once raised, `smp_ready` holds until such a transfer happens. Values presented while `smp_ready` is low do not affect the result.
- R6: Exactly NUM_SMP samples (default 16) are accepted per run. Their sum is shifted right by log2(NUM_SMP), which truncates the mean.
- R7: With battery mode off, `comp_val` = 512 − mean, as an 11-bit two's-complement value.
- R8: With battery mode on and `div_sel` = 1, `comp_val` = 3 × (512 − mean).
- R9: With battery mode on and `div_sel` = 0, `comp_val` = 3 × (512 − mean) / 2, with the division truncated toward zero (for example −3 gives −1).
- R10: A scaled value beyond the 11-bit range saturates to 1023 or −1024.
- R11: `done` is a one-cycle pulse two cycles after the final accepted sample. In that cycle `busy` and `cal_mode` are already 0 and `comp_val` is updated. `comp_val` then holds until the next `done`.
- R12: `start` while `busy` is ignored. The run in progress keeps its timing and finishes once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration run when idle |
| batt_en | input | 1 | Apply battery divider gain to the result |
| div_sel | input | 1 | Divider select: 1 gives ×3, 0 gives ×3/2 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when `comp_val` is refreshed |
| cal_mode | output | 1 | Compensation mode request to the converter on channel 0 |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready |
| smp_data | input | 10 | Sample stream data |
| comp_val | output | 11 | Signed compensation value |

## Verification
Each run feeds alternating pairs of sample values. Equal pairs give exact means at mid-scale, full scale and zero, which checks the sign and the range of the subtraction. Pairs one apart give a fractional mean, which shows whether the shift truncates. The gain cases separate ×3 from ×3/2, and a negative odd product shows whether the halving truncates toward zero or rounds down. Full-scale and zero inputs under ×3 and ×3/2 show where saturation applies. Further directed runs check freshness and back-pressure: junk data is offered while ready is low, the source delays its answer after ready rises, and a second start arrives mid-run. Together they separate a design that samples too early, samples too often or restarts from one that keeps the timing.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_GAP,
    ST_TAKE,
    ST_FINISH
  } cal_state_e;
endpackage

// File: rtl/cal_timer.sv
// Saturating up-counter; expired when the count reaches limit-1.
module cal_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == limit - CW'(1));
endmodule

// File: rtl/cal_accum.sv
// Sums NUM_SMP samples and presents the truncated mean.
module cal_accum #(
  parameter int SMP_W   = 10,
  parameter int NUM_SMP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic [SMP_W-1:0] data,
  output logic             last,
  output logic [SMP_W-1:0] mean
);
  localparam int SH    = $clog2(NUM_SMP);
  localparam int ACC_W = SMP_W + SH;

  logic [ACC_W-1:0] acc_q;
  logic [SH-1:0]    cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      acc_q <= acc_q + {{SH{1'b0}}, data};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = (cnt_q == SH'(NUM_SMP - 1));
  assign mean = acc_q[ACC_W-1:SH];
endmodule

// File: rtl/cal_gain.sv
// Mid-scale minus mean, optional x3 or x3/2 (toward zero), fit to OUT_W.
module cal_gain #(
  parameter int SMP_W = 10,
  parameter int OUT_W = 11
) (
  input  logic                    [SMP_W-1:0] mean,
  input  logic                                batt,
  input  logic                                div3,
  output logic signed             [OUT_W-1:0] comp
);
  localparam int RW = SMP_W + 1;
  localparam int PW = SMP_W + 3;
  localparam logic [SMP_W-1:0] MID = SMP_W'(1 << (SMP_W - 1));

  logic signed [RW-1:0] raw;
  logic signed [PW-1:0] rx, prod, adj, half, pick;

  always_comb begin
    raw  = $signed({1'b0, MID}) - $signed({1'b0, mean});
    rx   = {{2{raw[RW-1]}}, raw};
    prod = rx + (rx <<< 1);
    adj  = prod + $signed({{(PW-1){1'b0}}, prod[PW-1]});
    half = adj >>> 1;
    if (!batt)     pick = rx;
    else if (div3) pick = prod;
    else           pick = half;
  end

  generate
    if (OUT_W > PW) begin : g_wide
      assign comp = {{(OUT_W-PW){pick[PW-1]}}, pick};
    end else if (OUT_W == PW) begin : g_exact
      assign comp = pick;
    end else begin : g_sat
      localparam int HI_I = (1 << (OUT_W - 1)) - 1;
      localparam int LO_I = -(1 << (OUT_W - 1));
      localparam logic signed [PW-1:0] HI = PW'(HI_I);
      localparam logic signed [PW-1:0] LO = PW'(LO_I);
      always_comb begin
        if (pick > HI)      comp = HI[OUT_W-1:0];
        else if (pick < LO) comp = LO[OUT_W-1:0];
        else                comp = pick[OUT_W-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/adc_offset_cal.sv
module adc_offset_cal #(
  parameter int SMP_W      = 10,
  parameter int NUM_SMP    = 16,
  parameter int SETTLE_CYC = 200,
  parameter int GAP_CYC    = 12,
  parameter int OUT_W      = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    batt_en,
  input  logic                    div_sel,
  output logic                    busy,
  output logic                    done,
  output logic                    cal_mode,
  input  logic                    smp_valid,
  output logic                    smp_ready,
  input  logic [SMP_W-1:0]        smp_data,
  output logic signed [OUT_W-1:0] comp_val
);
  import adc_cal_pkg::*;

  localparam int TMAX = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] SET_L = TW'(SETTLE_CYC);
  localparam logic [TW-1:0] GAP_L = TW'(GAP_CYC);

  cal_state_e state_q, state_d;
  logic batt_q, div_q, done_q;
  logic signed [OUT_W-1:0] comp_q, comp_d;
  logic tmr_clr, tmr_exp, acc_clr, take, last;
  logic [TW-1:0] limit;
  logic [SMP_W-1:0] mean;

  assign take    = (state_q == ST_TAKE) && smp_valid;
  assign acc_clr = (state_q == ST_IDLE) && start;
  assign limit   = (state_q == ST_SETTLE) ? SET_L : GAP_L;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start)   state_d = ST_SETTLE;
      ST_SETTLE: if (tmr_exp) state_d = ST_GAP;
      ST_GAP:    if (tmr_exp) state_d = ST_TAKE;
      ST_TAKE:   if (take)    state_d = last ? ST_FINISH : ST_GAP;
      ST_FINISH:              state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  assign tmr_clr = (state_d != state_q) || (state_q == ST_IDLE);

  cal_timer #(.CW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .limit(limit), .expired(tmr_exp)
  );

  cal_accum #(.SMP_W(SMP_W), .NUM_SMP(NUM_SMP)) u_accum (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .take(take),
    .data(smp_data), .last(last), .mean(mean)
  );

  cal_gain #(.SMP_W(SMP_W), .OUT_W(OUT_W)) u_gain (
    .mean(mean), .batt(batt_q), .div3(div_q), .comp(comp_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      batt_q  <= 1'b0;
      div_q   <= 1'b0;
      done_q  <= 1'b0;
      comp_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_FINISH);
      if (acc_clr) begin
        batt_q <= batt_en;
        div_q  <= div_sel;
      end
      if (state_q == ST_FINISH) comp_q <= comp_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign cal_mode  = (state_q == ST_SETTLE) || (state_q == ST_GAP) || (state_q == ST_TAKE);
  assign smp_ready = (state_q == ST_TAKE);
  assign done      = done_q;
  assign comp_val  = comp_q;
endmodule

// File: rtl/adc_offset_cal_chk.sv
module adc_offset_cal_chk #(
  parameter int NUM_SMP = 16,
  parameter int OUT_W   = 11
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic                    cal_mode,
  input logic                    smp_valid,
  input logic                    smp_ready,
  input logic signed [OUT_W-1:0] comp_val
);
  localparam int HW = $clog2(NUM_SMP) + 2;
  logic [HW-1:0] hs_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || done) hs_cnt <= '0;
    else if (smp_valid && smp_ready) hs_cnt <= hs_cnt + 1'b1;
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && cal_mode));
  p_mode_in_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cal_mode |-> busy);
  p_gap_after_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);
  p_ready_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ready && !smp_valid) |=> smp_ready);
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hs_cnt <= HW'(NUM_SMP));
  p_count_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hs_cnt == HW'(NUM_SMP)));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !cal_mode));
  p_comp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(comp_val));
endmodule

bind adc_offset_cal adc_offset_cal_chk #(.NUM_SMP(NUM_SMP), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cal_mode(cal_mode), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .comp_val(comp_val)
);

// File: tb/tb_adc_offset_cal.sv
`timescale 1ns/1ps
module tb_adc_offset_cal;
  localparam int S = 200;
  localparam int G = 12;
  localparam int N = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, batt_en, div_sel, smp_valid;
  logic busy, done, cal_mode, smp_ready;
  logic [9:0] smp_data;
  logic signed [10:0] comp_val;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  adc_offset_cal dut (
    .clk(clk), .rst_n(rst_n), .start(start), .batt_en(batt_en), .div_sel(div_sel),
    .busy(busy), .done(done), .cal_mode(cal_mode), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .comp_val(comp_val)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // base, alt (samples alternate), battery, divider select, expected result
  localparam int NV = 11;
  localparam int T_BASE[NV] = '{512, 500, 1023, 0, 500, 500, 513, 0, 1023, 0, 510};
  localparam int T_ALT [NV] = '{512, 502, 1023, 0, 500, 500, 513, 0, 1023, 0, 511};
  localparam int T_BAT [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 0};
  localparam int T_DIV [NV] = '{0, 0, 0, 0, 1, 0, 0, 1, 1, 0, 0};
  localparam int T_EXP [NV] = '{0, 11, -511, 512, 36, 18, -1, 1023, -1024, 768, 2};

  function automatic string tag_of(input int i);
    if (i == 7 || i == 8) return "R10";     // saturation entries
    if (T_BAT[i] == 0)    return "R7";      // entry 10 also covers R6 truncation
    if (T_DIV[i] == 1)    return "R8";
    return "R9";                            // entry 6: -3/2 -> -1
  endfunction

  // hold: cycles the source waits after ready rises; junk: offer data while not ready
  task automatic run_cal(input int base, input int alt, input int bat, input int dv,
                         input bit junk, input int hold, input int restart_at,
                         input int exp, input string tag);
    int k = 0, cyc = 0, last_hs = -1, first = -1, gap_bad = 0, done_cyc = -1, w = 0;
    bit prev_rdy = 0;
    @(negedge clk);
    batt_en = bat[0]; div_sel = dv[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0; batt_en = ~bat[0]; div_sel = ~dv[0];   // R2: later changes ignored
    chk(busy && cal_mode, "R2 busy/cal_mode after start", int'(busy), 1);
    while (cyc < 3000) begin
      if (done) begin done_cyc = cyc; break; end
      start = (cyc == restart_at || cyc == restart_at + 1) ? 1'b1 : 1'b0;   // R12
      if (smp_ready && !prev_rdy) begin
        if (first < 0) first = cyc;
        else if (cyc - last_hs != G + 1) gap_bad++;
      end
      prev_rdy = smp_ready;
      if (smp_ready) begin
        if (w >= hold) begin
          smp_valid = 1'b1;
          smp_data  = (k % 2 == 1) ? 10'(alt) : 10'(base);
          last_hs = cyc; k++; w = 0;
        end else begin
          smp_valid = 1'b0; smp_data = 10'h000; w++;
        end
      end else begin
        smp_valid = junk;
        smp_data  = junk ? 10'(cyc * 37) : 10'h000;
      end
      @(negedge clk);
      cyc++;
    end
    smp_valid = 1'b0; start = 1'b0;
    chk(first == S + G, "R3 first ready cycle", first, S + G);
    chk(gap_bad == 0, "R4 ready gap after capture", gap_bad, 0);
    chk(k == N, "R6 samples accepted", k, N);
    chk(done_cyc == last_hs + 2, "R11 done timing", done_cyc, last_hs + 2);
    chk(!busy && !cal_mode, "R11 idle at done", int'(busy) + int'(cal_mode), 0);
    chk(int'(comp_val) == exp, tag, int'(comp_val), exp);
    @(negedge clk);
    chk(!done, "R11 done one cycle", int'(done), 0);
    chk(int'(comp_val) == exp && !busy, "R11 value held / R12 single run",
        int'(comp_val), exp);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R11 actual=0 expected=1 (run never completed)");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; batt_en = 1'b0; div_sel = 1'b0;
    smp_valid = 1'b0; smp_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !cal_mode && !smp_ready, "R1 controls low in reset",
        int'(busy) + int'(done) + int'(cal_mode) + int'(smp_ready), 0);
    chk(comp_val == 0, "R1 comp_val in reset", int'(comp_val), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !smp_ready, "R1 idle after reset", int'(busy), 0);

    for (int i = 0; i < NV; i++)
      run_cal(T_BASE[i], T_ALT[i], T_BAT[i], T_DIV[i], 1'b0, 0, -1, T_EXP[i], tag_of(i));

    // R5: junk offered while ready is low must not be taken
    run_cal(300, 300, 0, 0, 1'b1, 0, -1, 212, "R5 junk ignored");
    // R5: source answers late; ready must hold
    run_cal(700, 701, 0, 0, 1'b0, 3, -1, -188, "R5 ready hold");
    // R12: start during settle is ignored
    run_cal(520, 520, 1, 1, 1'b0, 0, 40, -24, "R12 restart ignored");
    // R12: start during capture phase is ignored
    run_cal(400, 400, 1, 0, 1'b1, 0, 260, 168, "R12 restart in capture");

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule